// File: doc/BRIEF.md
# Hot-Plug I/O Expander Controller

This block keeps an external I/O expander in step with the hot-plug control and indicator outputs of the downstream ports. It also holds a local copy of the expander's hot-plug inputs. The port logic presents its current output image and pulses a request whenever any bit of that image has to change. The controller then asks a shared SMBus master engine for a write transaction that carries the whole image. The expander reports input changes on one active-low interrupt line per downstream port. A falling edge on any of these lines makes the controller ask the engine for a read of the whole input image.

Only one transaction is outstanding at a time. Requests that arrive while the engine is busy are remembered. When both kinds are waiting, a write goes ahead of a read, so that the outputs stay current. A read that fails is issued again, and the input copy changes only when a read completes without error. After each successful read, every input bit that differs from the previous copy produces a one-cycle change pulse. No traffic starts until reset and configuration have finished.

Top module: `hpx_ctrl`

## Requirements
- R1: While `cfg_done` is low, no transaction is requested (`txn_req` stays 0). Requests and interrupt edges that arrive in that time are kept and served once `cfg_done` rises.
- R2: Each write request carries in `txn_wdata` the full `ind_image` as sampled in the cycle the write is issued, with `txn_rd` = 0.
- R3: A single `ind_req` pulse that arrives while the block is idle produces exactly one write.
- R4: If `ind_req` pulses while a write is in progress, exactly one more write follows that write, carrying the image current at its issue.
- R5: A high-to-low transition on either bit of `exp_int_n` (one active-low line per downstream port) produces one read request (`txn_rd` = 1).
- R6: `txn_req`, `txn_rd` and `txn_wdata` stay unchanged from issue until `txn_done`. When a write and a read are both pending, the write is issued first.
- R7: A read that completes with `txn_err` = 1 is issued again until it succeeds. `in_image` is loaded only from `txn_rdata` of a read completing with `txn_err` = 0.
- R8: In the cycle after a successful read completes, `in_chg` holds for one cycle the XOR of the old and new input images.
- R9: A write that completes with `txn_err` = 1 is issued again.
- R10: After reset, `txn_req` = 0, `in_image` = `IN_RST` (0 by default) and `in_chg` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Reset and configuration finished; traffic allowed |
| ind_req | input | 1 | Pulse: the output image has changed |
| ind_image | input | OUT_W | Current hot-plug output image |
| exp_int_n | input | NPORT | Active-low expander interrupts, one per downstream port |
| txn_req | output | 1 | Transaction request to the SMBus master engine, held until done |
| txn_rd | output | 1 | 1 = read input image, 0 = write output image |
| txn_wdata | output | OUT_W | Output image carried by a write |
| txn_done | input | 1 | Pulse: the engine has finished the transaction |
| txn_err | input | 1 | Qualifies `txn_done`: the transaction failed |
| txn_rdata | input | IN_W | Input image returned by a read, valid with `txn_done` |
| in_image | output | IN_W | Local copy of the expander's hot-plug inputs |
| in_chg | output | IN_W | One-cycle change pulses, one bit per input |

## Verification
The hardest state to reach is a new output request that lands while a write is already on the bus. This state has to be kept apart from a write that is merely pending. The bench watches `txn_req` and fires the second request only once the engine model has accepted the first write. Failed reads come from an error budget in the engine model. On a failed read the model returns the inverse of the true image, so a copy loaded from failed data would show up in both `in_image` and the change pulses.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2
   } hpx_state_e;
endpackage

// File: rtl/hpx_irq_edge.sv
module hpx_irq_edge #(
   parameter int NPORT       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] int_n,
   output logic             fall_any
);
   logic [NPORT-1:0] lvl;
   logic [NPORT-1:0] prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = int_n;
      end else begin : g_sync
         logic [NPORT-1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '1;
            end else begin
               chain[0] <= int_n;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign lvl = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '1;
      else        prev <= lvl;
   end

   assign fall_any = |(prev & ~lvl);

   a_r5_fall_is_edge: assert property (@(posedge clk) disable iff (!rst_n)
      fall_any |=> !fall_any || ($past(lvl) != lvl));
endmodule

// File: rtl/hpx_sched.sv
module hpx_sched
   import hpx_pkg::*;
#(
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_done,
   input  logic             ind_req,
   input  logic [OUT_W-1:0] ind_image,
   input  logic             irq_fall,
   input  logic             txn_done,
   input  logic             txn_err,
   output logic             txn_req,
   output logic             txn_rd,
   output logic [OUT_W-1:0] txn_wdata,
   output logic             rd_ok
);
   hpx_state_e state_q, state_d;
   logic wr_pend, rd_pend;
   logic start_wr, start_rd, wr_fail, rd_fail;
   logic [OUT_W-1:0] wdata_q;

   assign start_wr = (state_q == ST_IDLE) && cfg_done && wr_pend;
   assign start_rd = (state_q == ST_IDLE) && cfg_done && !wr_pend && rd_pend;
   assign wr_fail  = (state_q == ST_WRITE) && txn_done && txn_err;
   assign rd_fail  = (state_q == ST_READ)  && txn_done && txn_err;
   assign rd_ok    = (state_q == ST_READ)  && txn_done && !txn_err;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start_wr) state_d = ST_WRITE;
                   else if (start_rd) state_d = ST_READ;
         ST_WRITE: if (txn_done) state_d = ST_IDLE;
         ST_READ:  if (txn_done) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_pend <= 1'b0;
         rd_pend <= 1'b0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         wr_pend <= ind_req || (wr_pend && !start_wr) || wr_fail;
         rd_pend <= irq_fall || (rd_pend && !start_rd) || rd_fail;
         if (start_wr) wdata_q <= ind_image;
      end
   end

   assign txn_req   = (state_q != ST_IDLE);
   assign txn_rd    = (state_q == ST_READ);
   assign txn_wdata = wdata_q;

   a_r1_quiet_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (!txn_req && !cfg_done) |=> !txn_req);
   a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_req && !txn_done) |=> txn_req && $stable(txn_rd) && $stable(txn_wdata));
   a_r6_write_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txn_req) |-> !(txn_rd && $past(wr_pend)));
   a_r4_req_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ind_req |=> wr_pend || (txn_req && !txn_rd));
   a_r5_irq_kept: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fall |=> rd_pend);
endmodule

// File: rtl/hpx_in_image.sv
module hpx_in_image #(
   parameter int              IN_W   = 8,
   parameter logic [IN_W-1:0] IN_RST = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd,
   input  logic [IN_W-1:0] rdata,
   output logic [IN_W-1:0] image,
   output logic [IN_W-1:0] chg
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         image <= IN_RST;
         chg   <= '0;
      end else begin
         chg <= upd ? (rdata ^ image) : '0;
         if (upd) image <= rdata;
      end
   end

   a_r7_load_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (image != $past(image)) |-> $past(upd));
   a_r8_chg_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |-> (image != $past(image)));
   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |=> (chg == '0) || $past(upd));
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl #(
   parameter int              NPORT       = 2,
   parameter int              OUT_W       = 8,
   parameter int              IN_W        = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [IN_W-1:0] IN_RST      = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_done,
   input  logic             ind_req,
   input  logic [OUT_W-1:0] ind_image,
   input  logic [NPORT-1:0] exp_int_n,
   output logic             txn_req,
   output logic             txn_rd,
   output logic [OUT_W-1:0] txn_wdata,
   input  logic             txn_done,
   input  logic             txn_err,
   input  logic [IN_W-1:0]  txn_rdata,
   output logic [IN_W-1:0]  in_image,
   output logic [IN_W-1:0]  in_chg
);
   generate
      if (NPORT < 1) begin : g_bad_nport
         $error("hpx_ctrl: NPORT must be at least 1");
      end
      if (OUT_W < 1 || IN_W < 1) begin : g_bad_width
         $error("hpx_ctrl: image widths must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("hpx_ctrl: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic irq_fall;
   logic rd_ok;

   hpx_irq_edge #(.NPORT(NPORT), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .int_n    (exp_int_n),
      .fall_any (irq_fall)
   );

   hpx_sched #(.OUT_W(OUT_W)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_done  (cfg_done),
      .ind_req   (ind_req),
      .ind_image (ind_image),
      .irq_fall  (irq_fall),
      .txn_done  (txn_done),
      .txn_err   (txn_err),
      .txn_req   (txn_req),
      .txn_rd    (txn_rd),
      .txn_wdata (txn_wdata),
      .rd_ok     (rd_ok)
   );

   hpx_in_image #(.IN_W(IN_W), .IN_RST(IN_RST)) u_img (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (rd_ok),
      .rdata (txn_rdata),
      .image (in_image),
      .chg   (in_chg)
   );

   a_r10_idle_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !txn_req && (in_chg == '0));
endmodule

// File: tb/sim_hpx_ctrl.sv
module sim_hpx_ctrl;
   localparam int CLK_P = 10;
   localparam int LAT   = 4;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       cfg_done = 0;
   logic       ind_req = 0;
   logic [7:0] ind_image = 0;
   logic [1:0] exp_int_n = 2'b11;
   logic       txn_req, txn_rd;
   logic [7:0] txn_wdata;
   logic       txn_done = 0, txn_err = 0;
   logic [7:0] txn_rdata = 0;
   logic [7:0] in_image, in_chg;

   always #(CLK_P/2) clk = ~clk;

   hpx_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .ind_req(ind_req),
      .ind_image(ind_image), .exp_int_n(exp_int_n), .txn_req(txn_req),
      .txn_rd(txn_rd), .txn_wdata(txn_wdata), .txn_done(txn_done),
      .txn_err(txn_err), .txn_rdata(txn_rdata), .in_image(in_image),
      .in_chg(in_chg)
   );

   int errors = 0, checks = 0;
   int rd_err_limit = 0, wr_err_limit = 0;
   logic [7:0] exp_inputs = 8'h81;

   // engine model state (written only by the model)
   int n_txn = 0, n_wr = 0, n_rd = 0, n_rd_ok = 0, rd_err_used = 0, wr_err_used = 0;
   int chg_cnt = 0;
   logic [7:0] chg_last = 0, last_wd = 0, cap_wd = 0, kinds = 0;
   logic busy = 0, cap_rd = 0;
   int lat = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         busy = 0; txn_done = 0; txn_err = 0;
      end else begin
         txn_done = 0; txn_err = 0;
         if (in_chg != 0) begin chg_cnt++; chg_last = in_chg; end
         if (txn_req && !busy) begin
            busy = 1; lat = LAT; cap_rd = txn_rd; cap_wd = txn_wdata;
            kinds = {kinds[6:0], txn_rd}; n_txn++;
         end else if (busy) begin
            if (lat == 0) begin
               busy = 0; txn_done = 1;
               if (cap_rd) begin
                  n_rd++;
                  if (rd_err_used < rd_err_limit) begin
                     rd_err_used++; txn_err = 1; txn_rdata = ~exp_inputs;
                  end else begin
                     n_rd_ok++; txn_rdata = exp_inputs;
                  end
               end else begin
                  n_wr++; last_wd = cap_wd;
                  if (wr_err_used < wr_err_limit) begin wr_err_used++; txn_err = 1; end
               end
            end else lat--;
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_req(input logic [7:0] img);
      @(negedge clk); ind_image = img; ind_req = 1;
      @(negedge clk); ind_req = 0;
   endtask

   task automatic wait_wr(input int target);
      for (int i = 0; i < 500 && n_wr < target; i++) @(negedge clk);
   endtask

   task automatic wait_rdok(input int target);
      for (int i = 0; i < 500 && n_rd_ok < target; i++) @(negedge clk);
   endtask

   localparam logic [7:0] VEC [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h00};

   int base, rbase, cbase;

   initial begin
      wait_cyc(3);
      // R10 reset state
      chk("R10 txn_req", txn_req, 0);
      chk("R10 in_image", in_image, 0);
      chk("R10 in_chg", in_chg, 0);
      @(negedge clk); rst_n = 1;

      // R1: no traffic before configuration is done; work is kept
      pulse_req(8'h3C);
      exp_int_n[0] = 0;
      wait_cyc(20);
      chk("R1 no txn before cfg", n_txn, 0);
      cfg_done = 1;
      exp_int_n[0] = 1;
      wait_rdok(1); wait_cyc(3);
      chk("R6 write then read order", kinds[1:0], 2'b01);
      chk("R1 deferred write data", last_wd, 8'h3C);
      chk("R8 first image", in_image, 8'h81);
      chk("R8 first change pulse", chg_last, 8'h81);

      // R2 / R3: table of output images
      foreach (VEC[k]) begin
         base = n_wr;
         pulse_req(VEC[k]);
         wait_wr(base + 1); wait_cyc(2);
         chk("R2 write data", last_wd, VEC[k]);
      end
      base = n_wr;
      wait_cyc(30);
      chk("R3 no extra write", n_wr, base);

      // R4: request during a write in progress
      base = n_wr;
      pulse_req(8'h11);
      for (int i = 0; i < 50 && !busy; i++) @(negedge clk);
      pulse_req(8'h22);
      wait_wr(base + 2); wait_cyc(30);
      chk("R4 exactly one more write", n_wr - base, 2);
      chk("R4 latest image sent", last_wd, 8'h22);

      // R5 / R8: interrupt on port 1
      rbase = n_rd_ok; cbase = chg_cnt;
      exp_inputs = 8'hC3;
      @(negedge clk); exp_int_n[1] = 0;
      wait_rdok(rbase + 1); wait_cyc(3);
      exp_int_n[1] = 1;
      chk("R5 port1 read image", in_image, 8'hC3);
      chk("R8 change bits", chg_last, 8'h81 ^ 8'hC3);
      chk("R8 single pulse", chg_cnt - cbase, 1);

      // R7: failed reads are retried, copy only from good data
      rd_err_limit = rd_err_used + 2;
      rbase = n_rd_ok; base = n_rd; cbase = chg_cnt;
      exp_inputs = 8'h0F;
      @(negedge clk); exp_int_n[0] = 0;
      wait_rdok(rbase + 1); wait_cyc(3);
      exp_int_n[0] = 1;
      chk("R7 read attempts", n_rd - base, 3);
      chk("R7 image from good read", in_image, 8'h0F);
      chk("R7 change bits", chg_last, 8'hC3 ^ 8'h0F);
      chk("R7 single pulse", chg_cnt - cbase, 1);

      // R9: failed write is reissued
      wr_err_limit = wr_err_used + 1;
      base = n_wr;
      pulse_req(8'h77);
      wait_wr(base + 2); wait_cyc(30);
      chk("R9 write attempts", n_wr - base, 2);
      chk("R9 write data", last_wd, 8'h77);

      // R6: write and read both pending while busy -> write first
      wait_cyc(5);
      exp_inputs = 8'h0E;
      pulse_req(8'h44);
      for (int i = 0; i < 50 && !busy; i++) @(negedge clk);
      exp_int_n[1] = 0;
      pulse_req(8'h55);
      rbase = n_rd_ok;
      wait_rdok(rbase + 1); wait_cyc(3);
      exp_int_n[1] = 1;
      chk("R6 pending write before read", kinds[1:0], 2'b01);
      chk("R6 write data", last_wd, 8'h55);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule